// File: doc/BRIEF.md
# Supervisory Reset Sequencer

This block merges several fault indications into system reset outputs whose release is held back by a selectable stretch time. The primary domain reacts to a low primary supply, a low secondary supply, a low auxiliary monitor, a held manual-reset pin and a single-cycle watchdog expiry. The secondary domain reacts only to the two supply flags and the manual reset. Both domains release only after a full timeout with no fault present. A fault that returns before the timeout ends starts the count again.

Time is measured in ticks. Each tick is `PRESCALE` clock cycles, and one tick corresponds to 0.15 ms at the intended clock. The 3-bit select code picks one of eight tick counts that match nominal periods from 1.65 ms to 1680 ms. The flags and the manual-reset pin are asynchronous and pass through a two-flop synchronizer. The manual-reset pin then goes through a low-width filter that rejects short glitches. The watchdog pulse and the select code are synchronous. A one-cycle event pulse marks each new assertion of the primary reset, for use by a downstream watchdog.

Top module: `sup_reset_seq`

## Requirements
- R1: The primary reset asserts when any of these is high after synchronization: the primary supply flag, the secondary supply flag, the auxiliary flag, or the filtered manual reset. It also asserts on a watchdog pulse. A supply or auxiliary flag raised before a clock edge E0 shows as `rst_main_n`=0 after edge E2.
- R2: After the last supply or auxiliary fault is removed (driven low before edge E0), the primary reset releases after exactly `PRESCALE`*ticks+2 clock edges.
- R3: If a supply or auxiliary fault returns while the stretch count is running, the count restarts from zero. The release then comes `PRESCALE`*ticks+2 edges after the final removal.
- R4: A single-cycle watchdog pulse asserts the primary reset after the edge that samples it. The reset then stays asserted for a full period, releasing `PRESCALE`*ticks edges after the following edge. If the pulse lands on the final counting edge, the count restarts.
- R5: The secondary reset `rst_sec_n` asserts only for the supply flags and the manual reset. It uses the same period. It never asserts for the auxiliary flag or the watchdog, and it is never asserted while the primary reset is released.
- R6: `tsel` codes 0..7 select 11, 88, 175, 350, 1400, 2800, 5600 and 11200 ticks. These correspond to 1.65, 13.2, 26.25, 52.5, 210, 420, 840 and 1680 ms.
- R7: A manual-reset low lasting fewer than `MR_FILT` clock cycles has no effect on either output. A low lasting `MR_FILT` cycles or more asserts both resets. Both then release `PRESCALE`*ticks+3 edges after the pin returns high.
- R8: `rst_main` is always the exact inverse of `rst_main_n`.
- R9: While `rst` is high, all three resets are asserted and `rst_event` is 0. After `rst` falls with no fault present, both active-low resets release after exactly `PRESCALE`*ticks edges.
- R10: `rst_event` is high for exactly one cycle, in the cycle in which `rst_main_n` first falls. It does not pulse on a fault that arrives while the primary reset is already asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| supply1_low | input | 1 | Primary supply below threshold, asynchronous |
| supply2_low | input | 1 | Secondary supply below threshold, asynchronous |
| aux_low | input | 1 | Auxiliary monitor below threshold, asynchronous |
| mr_n | input | 1 | Manual reset pin, active low, asynchronous |
| wdog_expire | input | 1 | Watchdog expiry pulse, synchronous |
| tsel | input | 3 | Stretch period select code |
| rst_main_n | output | 1 | Primary reset, active low |
| rst_main | output | 1 | Primary reset, active high |
| rst_sec_n | output | 1 | Secondary reset, active low |
| rst_event | output | 1 | One-cycle pulse when the primary reset asserts |

## Verification
Two functions can meet in one cycle: the stretch counter's final counting edge and a newly arriving watchdog expiry. The bench removes a supply fault and counts exactly `PRESCALE`*ticks+1 edges. It then drives the watchdog pulse so that it is sampled on the very edge that would otherwise release the reset. The expected result: the primary reset stays low with no new event pulse and releases one full period later. The secondary reset, which ignores the watchdog, releases on that same edge.

// File: rtl/sup_pkg.sv
package sup_pkg;

  localparam int unsigned CODE_W = 3;
  localparam int unsigned TICK_W = 14;

  typedef logic [TICK_W-1:0] tick_cnt_t;

  typedef struct packed {
    logic wdog;
    logic mr;
    logic aux;
    logic sup2;
    logic sup1;
  } fault_vec_t;

  // Stretch length in ticks of 0.15 ms for each select code.
  function automatic tick_cnt_t period_ticks(input logic [CODE_W-1:0] code);
    tick_cnt_t t;
    case (code)
      3'd0:    t = TICK_W'(11);
      3'd1:    t = TICK_W'(88);
      3'd2:    t = TICK_W'(175);
      3'd3:    t = TICK_W'(350);
      3'd4:    t = TICK_W'(1400);
      3'd5:    t = TICK_W'(2800);
      3'd6:    t = TICK_W'(5600);
      default: t = TICK_W'(11200);
    endcase
    return t;
  endfunction

endpackage

// File: rtl/sup_sync.sv
module sup_sync #(
  parameter int unsigned       WIDTH   = 1,
  parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= RST_VAL;
      stab_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;

endmodule

// File: rtl/sup_mr_filter.sv
module sup_mr_filter #(
  parameter int unsigned MIN_LOW = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n_i,
  output logic fault_o
);

  localparam int unsigned CNT_W = (MIN_LOW > 1) ? $clog2(MIN_LOW) : 1;

  logic [CNT_W-1:0] low_cnt_q;
  logic             fault_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt_q <= '0;
      fault_q   <= 1'b0;
    end else if (pin_n_i) begin
      low_cnt_q <= '0;
      fault_q   <= 1'b0;
    end else if (low_cnt_q == CNT_W'(MIN_LOW - 1)) begin
      fault_q   <= 1'b1;
    end else begin
      low_cnt_q <= low_cnt_q + 1'b1;
    end
  end

  assign fault_o = fault_q;

endmodule

// File: rtl/sup_stretch.sv
module sup_stretch
  import sup_pkg::*;
#(
  parameter int unsigned PRESCALE = 30000
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      fault_i,
  input  tick_cnt_t period_i,
  output logic      active_o
);

  localparam int unsigned SUB_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic [SUB_W-1:0] sub_q;
  tick_cnt_t        tick_q;
  logic             on_q;
  logic             tick_end;
  logic             last_tick;

  assign tick_end  = (sub_q == SUB_W'(PRESCALE - 1));
  assign last_tick = (tick_q >= period_i - TICK_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      on_q   <= 1'b1;
      sub_q  <= '0;
      tick_q <= '0;
    end else if (fault_i) begin
      on_q   <= 1'b1;
      sub_q  <= '0;
      tick_q <= '0;
    end else if (on_q) begin
      if (tick_end) begin
        sub_q <= '0;
        if (last_tick) begin
          on_q   <= 1'b0;
          tick_q <= '0;
        end else begin
          tick_q <= tick_q + 1'b1;
        end
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

  assign active_o = on_q;

endmodule

// File: rtl/sup_reset_seq.sv
module sup_reset_seq
  import sup_pkg::*;
#(
  parameter int unsigned PRESCALE = 30000,
  parameter int unsigned MR_FILT  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              supply1_low,
  input  logic              supply2_low,
  input  logic              aux_low,
  input  logic              mr_n,
  input  logic              wdog_expire,
  input  logic [CODE_W-1:0] tsel,
  output logic              rst_main_n,
  output logic              rst_main,
  output logic              rst_sec_n,
  output logic              rst_event
);

  localparam int unsigned NSYNC = 4;
  localparam int unsigned NDOM  = 2;

  logic [NSYNC-1:0] sync_q;
  logic             mr_fault;
  fault_vec_t       flt;
  logic [NDOM-1:0]  dom_fault;
  logic [NDOM-1:0]  dom_on;
  tick_cnt_t        period;
  logic             evt_q;

  sup_sync #(
    .WIDTH  (NSYNC),
    .RST_VAL({1'b1, {(NSYNC-1){1'b0}}})
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({mr_n, aux_low, supply2_low, supply1_low}),
    .q_o (sync_q)
  );

  sup_mr_filter #(
    .MIN_LOW(MR_FILT)
  ) u_mr (
    .clk     (clk),
    .rst     (rst),
    .pin_n_i (sync_q[3]),
    .fault_o (mr_fault)
  );

  assign flt.sup1 = sync_q[0];
  assign flt.sup2 = sync_q[1];
  assign flt.aux  = sync_q[2];
  assign flt.mr   = mr_fault;
  assign flt.wdog = wdog_expire;

  // Domain 0: every source. Domain 1: supplies and manual reset only.
  assign dom_fault[0] = |flt;
  assign dom_fault[1] = flt.sup1 | flt.sup2 | flt.mr;

  assign period = period_ticks(tsel);

  generate
    for (genvar g = 0; g < NDOM; g++) begin : g_dom
      sup_stretch #(
        .PRESCALE(PRESCALE)
      ) u_str (
        .clk      (clk),
        .rst      (rst),
        .fault_i  (dom_fault[g]),
        .period_i (period),
        .active_o (dom_on[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= dom_fault[0] & ~dom_on[0];
  end

  assign rst_main_n = ~dom_on[0];
  assign rst_main   = dom_on[0];
  assign rst_sec_n  = ~dom_on[1];
  assign rst_event  = evt_q;

endmodule

// File: rtl/sup_reset_seq_chk.sv
module sup_reset_seq_chk (
  input logic clk,
  input logic rst,
  input logic wdog_expire,
  input logic rst_main_n,
  input logic rst_sec_n,
  input logic rst_event
);

  assert_wdog_asserts_R4: assert property (@(posedge clk) disable iff (rst)
    wdog_expire |=> !rst_main_n);

  assert_no_release_on_wdog_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_main_n) |-> !$past(wdog_expire));

  assert_sec_within_main_R5: assert property (@(posedge clk) disable iff (rst)
    !rst_sec_n |-> !rst_main_n);

  assert_event_single_R10: assert property (@(posedge clk) disable iff (rst)
    rst_event |=> !rst_event);

  assert_event_on_fall_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_main_n) |-> rst_event);

  assert_event_when_low_R10: assert property (@(posedge clk) disable iff (rst)
    rst_event |-> !rst_main_n);

endmodule

bind sup_reset_seq sup_reset_seq_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .wdog_expire (wdog_expire),
  .rst_main_n  (rst_main_n),
  .rst_sec_n   (rst_sec_n),
  .rst_event   (rst_event)
);

// File: tb/sup_reset_seq_tb.sv
module sup_reset_seq_tb;

  localparam int PRESCALE = 2;
  localparam int MR_FILT  = 4;
  localparam int LIMIT    = 30000;

  logic       clk = 1'b0;
  logic       rst;
  logic       supply1_low, supply2_low, aux_low, mr_n, wdog_expire;
  logic [2:0] tsel;
  logic       rst_main_n, rst_main, rst_sec_n, rst_event;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  sup_reset_seq #(.PRESCALE(PRESCALE), .MR_FILT(MR_FILT)) u_dut (
    .clk(clk), .rst(rst), .supply1_low(supply1_low), .supply2_low(supply2_low),
    .aux_low(aux_low), .mr_n(mr_n), .wdog_expire(wdog_expire), .tsel(tsel),
    .rst_main_n(rst_main_n), .rst_main(rst_main), .rst_sec_n(rst_sec_n),
    .rst_event(rst_event)
  );

  function automatic int ticks_of(input int code);
    int t[8] = '{11, 88, 175, 350, 1400, 2800, 5600, 11200};
    return t[code];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  // Counts negedges until the primary reset releases after having been seen asserted.
  task automatic measure(output int cm, output int cs, output bit inv_bad);
    bit seen_m, seen_s, rel_s;
    int cnt;
    seen_m = (rst_main_n == 1'b0);
    seen_s = (rst_sec_n == 1'b0);
    rel_s = 0; cs = -1; cnt = 0; inv_bad = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (rst_main != !rst_main_n) inv_bad = 1;
      if (!rst_main_n) seen_m = 1;
      if (!rst_sec_n) seen_s = 1;
      if (seen_s && rst_sec_n && !rel_s) begin rel_s = 1; cs = cnt; end
    end while (!(seen_m && rst_main_n) && cnt < LIMIT);
    cm = cnt;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int cm, cs, pn;
    bit ib;
    rst = 1; supply1_low = 0; supply2_low = 0; aux_low = 0; mr_n = 1;
    wdog_expire = 0; tsel = 3'd0;
    repeat (4) @(negedge clk);
    chk(rst_main_n == 0 && rst_main == 1 && rst_sec_n == 0 && rst_event == 0,
        "R9 reset state", {rst_main_n, rst_main, rst_sec_n, rst_event}, 4'b0100);
    rst = 0;
    measure(cm, cs, ib);
    pn = PRESCALE * ticks_of(0);
    chk(cm == pn, "R9 power-on release main", cm, pn);
    chk(cs == pn, "R9 power-on release sec", cs, pn);
    chk(!ib, "R8 inverse output", ib, 0);

    // R1 R2 R6 sweep over every select code
    for (int c = 0; c < 8; c++) begin
      tsel = 3'(c);
      pn = PRESCALE * ticks_of(c);
      @(negedge clk);
      supply1_low = 1;
      @(negedge clk);
      @(negedge clk);
      chk(rst_main_n == 1, "R1 latency not yet", rst_main_n, 1);
      @(negedge clk);
      chk(rst_main_n == 0 && rst_sec_n == 0, "R1 supply asserts", {rst_main_n, rst_sec_n}, 0);
      chk(rst_event == 1, "R10 event on assert", rst_event, 1);
      @(negedge clk);
      chk(rst_event == 0, "R10 event one cycle", rst_event, 0);
      supply1_low = 0;
      measure(cm, cs, ib);
      chk(cm == pn + 2, "R2 R6 main release", cm, pn + 2);
      chk(cs == pn + 2, "R6 sec release", cs, pn + 2);
      chk(!ib, "R8 inverse output", ib, 0);
    end

    tsel = 3'd0;
    pn = PRESCALE * ticks_of(0);

    // Auxiliary flag: primary only
    @(negedge clk);
    aux_low = 1;
    repeat (5) @(negedge clk);
    chk(rst_main_n == 0, "R1 aux asserts main", rst_main_n, 0);
    chk(rst_sec_n == 1, "R5 aux ignored by sec", rst_sec_n, 1);
    aux_low = 0;
    measure(cm, cs, ib);
    chk(cm == pn + 2, "R2 aux release", cm, pn + 2);
    chk(cs == -1, "R5 sec never asserted for aux", cs, -1);

    // Watchdog pulse
    @(negedge clk);
    wdog_expire = 1;
    @(negedge clk);
    wdog_expire = 0;
    chk(rst_main_n == 0 && rst_event == 1, "R4 wdog asserts", {rst_main_n, rst_event}, 1);
    chk(rst_sec_n == 1, "R5 wdog ignored by sec", rst_sec_n, 1);
    measure(cm, cs, ib);
    chk(cm == pn, "R4 wdog full period", cm, pn);
    chk(cs == -1, "R5 sec never asserted for wdog", cs, -1);

    // Retrigger mid-count
    @(negedge clk);
    supply2_low = 1;
    repeat (4) @(negedge clk);
    supply2_low = 0;
    repeat (12) @(negedge clk);
    chk(rst_main_n == 0, "R3 still counting", rst_main_n, 0);
    supply2_low = 1;
    repeat (2) @(negedge clk);
    supply2_low = 0;
    measure(cm, cs, ib);
    chk(cm == pn + 2, "R3 restart main", cm, pn + 2);
    chk(cs == pn + 2, "R3 restart sec", cs, pn + 2);

    // Watchdog lands on the final counting edge
    @(negedge clk);
    supply1_low = 1;
    repeat (5) @(negedge clk);
    supply1_low = 0;
    repeat (pn + 1) @(negedge clk);
    chk(rst_main_n == 0, "R4 before final edge", rst_main_n, 0);
    wdog_expire = 1;
    @(negedge clk);
    wdog_expire = 0;
    chk(rst_main_n == 0, "R4 coincident wdog holds reset", rst_main_n, 0);
    chk(rst_event == 0, "R10 no event while asserted", rst_event, 0);
    chk(rst_sec_n == 1, "R5 sec released on final edge", rst_sec_n, 1);
    measure(cm, cs, ib);
    chk(cm == pn, "R4 coincident restart period", cm, pn);

    // Manual reset width sweep
    for (int l = 1; l <= 7; l++) begin
      bit low_seen;
      @(negedge clk);
      mr_n = 0;
      repeat (l) @(negedge clk);
      mr_n = 1;
      if (l < MR_FILT) begin
        low_seen = 0;
        repeat (20) begin
          @(negedge clk);
          if (!rst_main_n || !rst_sec_n) low_seen = 1;
        end
        chk(!low_seen, "R7 short manual low ignored", low_seen, 0);
      end else begin
        measure(cm, cs, ib);
        chk(cm == pn + 3, "R7 manual release main", cm, pn + 3);
        chk(cs == pn + 3, "R7 manual release sec", cs, pn + 3);
      end
    end

    finish_run();
  end

endmodule